// File: doc/BRIEF.md
# Configurable AXI4-Lite Register File

A bank of 32-bit memory-mapped registers reached through an AXI4-Lite subordinate port. Parameter vectors give each register a byte address, an access mode, a reset value and an auto-clear mask. The fabric side sees every register's current value on a flat output bus. It can feed each register through a per-register data input and a capture strobe. It also receives two one-cycle hit vectors, one for bus writes and one for bus reads.

Eight access modes are available:

- Constant, with no storage.
- Registered status.
- Pass-through status.
- Control, with byte enables and auto-clear.
- Value latch, cleared by a bus read.
- Value latch, cleared by a bus write.
- Sticky-OR bits, cleared to zero by a bus read.
- Sticky-AND bits, set to all ones by a bus read.

Accesses that hit no table entry complete with a configurable error code. Upper address bits can be treated as a base address and dropped.

Top module: `axil_regfile`

## Requirements
- R1: While rst_ni is low, every stored register takes its configured initial value. BVALID, RVALID and both hit vectors are low.
- R2: A bus access that decodes to register i raises bit i of wr_hit_o (write) or rd_hit_o (read) for exactly one cycle. wr_hit_o is aligned with the first BVALID cycle. rd_hit_o is aligned with the first RVALID cycle. An access that decodes to no register raises no hit bit.
- R3: An access to an address outside the table completes with ERR_RESP, which defaults to 2'b11. A read of such an address returns zero data. A mapped access returns 2'b00.
- R4: With IGNORE_HIGH set, only the lowest DEC_W address bits are compared. DEC_W is the bit count needed to cover the end of the highest register, which is 6 with the default table. Bits [1:0] are never compared.
- R5: For a control register (mode 3), a bus write updates only the bytes whose WSTRB bit is set. A fabric strobe loads the whole word. Any bit in the auto-clear mask reads as one for a single cycle after it is loaded and is zero after that.
- R6: A constant register (mode 0) always shows its initial value and ignores bus writes. A pass-through register (mode 2) shows fab_d_i combinationally on reg_q_o and on bus reads.
- R7: A value latch (mode 4 read-clear, mode 5 write-clear) captures a strobed input only while it holds its initial value. It then stays frozen until a bus read (mode 4) or a bus write (mode 5) restores the initial value. Write data is discarded in mode 5.
- R8: A sticky-high register (mode 6) ORs strobed input into its content, and a bus read returns the content and clears it to zero. A sticky-low register (mode 7) ANDs strobed input in, and a bus read returns the content and sets it to all ones.
- R9: When a bus clear and a fabric strobe reach the same register in the same cycle, the clear wins. The read returns the prior content and the strobed data is dropped.
- R10: BVALID holds with a stable BRESP until BREADY is high. RVALID holds with stable RDATA and RRESP until RREADY is high.
- R11: A registered status register (mode 1) loads fab_d_i on its strobe, and bus writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_awaddr_i | input | AW | Write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | 32 | Write data |
| s_wstrb_i | input | 4 | Write byte enables |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response code |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | AW | Read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | 32 | Read data |
| s_rresp_o | output | 2 | Read response code |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |
| reg_q_o | output | N_REGS*32 | Current value of every register, register i at bits [32i+31:32i] |
| fab_d_i | input | N_REGS*32 | Fabric input word per register |
| fab_stb_i | input | N_REGS | Fabric capture strobe per register |
| wr_hit_o | output | N_REGS | One-cycle pulse per register on a decoded bus write |
| rd_hit_o | output | N_REGS | One-cycle pulse per register on a decoded bus read |

## Verification
The two functions that can collide are the bus-side clear of a latch or sticky register and the fabric capture into that same register. The bench provokes the collision by raising fab_stb_i in the very cycle whose closing edge accepts ARVALID. The result is judged in two places: the returned RDATA must carry the content from before that edge, and reg_q_o must afterwards hold the cleared value with no trace of the strobed word. A later lone strobe must then be captured normally. The auto-clear control register is also loaded from both sides, and the bench checks that the masked bit drops one cycle after each load.

// File: rtl/axil_regfile_pkg.sv
package axil_regfile_pkg;
  localparam int unsigned DW = 32;

  typedef logic [3:0] mode_t;
  localparam mode_t M_CONST     = 4'd0;
  localparam mode_t M_STAT      = 4'd1;
  localparam mode_t M_PASS      = 4'd2;
  localparam mode_t M_CTRL      = 4'd3;
  localparam mode_t M_LATCH_RD  = 4'd4;
  localparam mode_t M_LATCH_WR  = 4'd5;
  localparam mode_t M_STICKY_HI = 4'd6;
  localparam mode_t M_STICKY_LO = 4'd7;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam logic [1:0] RESP_DECERR = 2'b11;
endpackage

// File: rtl/axil_regfile_cell.sv
module axil_regfile_cell import axil_regfile_pkg::*; #(
  parameter mode_t          MODE     = M_CTRL,
  parameter logic [DW-1:0]  INIT     = '0,
  parameter logic [DW-1:0]  CLR      = '0,
  parameter bit             RST_INIT = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [3:0]    wstrb_i,
  input  logic          stb_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  if (MODE == M_CONST || MODE == M_PASS) begin : g_nostore
    assign q_o = (MODE == M_CONST) ? INIT : d_i;
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, bus_wr_i, bus_rd_i, wdata_i, wstrb_i, stb_i, d_i};
  end else begin : g_store
    logic [DW-1:0] q, nxt;

    always_comb begin
      nxt = q;
      case (MODE)
        M_STAT: if (stb_i) nxt = d_i;
        M_CTRL: begin
          nxt = q & ~CLR;
          if (bus_wr_i) begin
            for (int b = 0; b < DW/8; b++)
              if (wstrb_i[b]) nxt[b*8 +: 8] = wdata_i[b*8 +: 8];
          end else if (stb_i) begin
            nxt = d_i;
          end
        end
        M_LATCH_RD: begin
          if (bus_rd_i) nxt = INIT;
          else if (stb_i && q == INIT) nxt = d_i;
        end
        M_LATCH_WR: begin
          if (bus_wr_i) nxt = INIT;
          else if (stb_i && q == INIT) nxt = d_i;
        end
        M_STICKY_HI: begin
          if (bus_rd_i) nxt = '0;
          else if (stb_i) nxt = q | d_i;
        end
        M_STICKY_LO: begin
          if (bus_rd_i) nxt = '1;
          else if (stb_i) nxt = q & d_i;
        end
        default: nxt = q;
      endcase
    end

    if (RST_INIT) begin : g_rst
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= INIT;
        else         q <= nxt;
      end
    end else begin : g_norst
      always_ff @(posedge clk_i) q <= nxt;
      logic unused_rst;
      assign unused_rst = rst_ni;
    end

    assign q_o = q;
  end
endmodule

// File: rtl/axil_regfile_wr.sv
module axil_regfile_wr import axil_regfile_pkg::*; #(
  parameter int         AW       = 32,
  parameter logic [1:0] ERR_RESP = RESP_DECERR
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] awaddr_i,
  input  logic          awvalid_i,
  output logic          awready_o,
  input  logic [DW-1:0] wdata_i,
  input  logic [3:0]    wstrb_i,
  input  logic          wvalid_i,
  output logic          wready_o,
  output logic [1:0]    bresp_o,
  output logic          bvalid_o,
  input  logic          bready_i,
  input  logic          miss_i,
  output logic          fire_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic [3:0]    strb_o
);
  logic aw_full, w_full;

  assign awready_o = !aw_full && !bvalid_o;
  assign wready_o  = !w_full && !bvalid_o;
  assign fire_o    = aw_full && w_full && !bvalid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_full  <= 1'b0;
      w_full   <= 1'b0;
      bvalid_o <= 1'b0;
      bresp_o  <= RESP_OKAY;
      addr_o   <= '0;
      data_o   <= '0;
      strb_o   <= '0;
    end else begin
      if (awvalid_i && awready_o) begin
        aw_full <= 1'b1;
        addr_o  <= awaddr_i;
      end
      if (wvalid_i && wready_o) begin
        w_full <= 1'b1;
        data_o <= wdata_i;
        strb_o <= wstrb_i;
      end
      if (fire_o) begin
        aw_full  <= 1'b0;
        w_full   <= 1'b0;
        bvalid_o <= 1'b1;
        bresp_o  <= miss_i ? ERR_RESP : RESP_OKAY;
      end else if (bvalid_o && bready_i) begin
        bvalid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/axil_regfile_rd.sv
module axil_regfile_rd import axil_regfile_pkg::*; #(
  parameter int         N_REGS   = 8,
  parameter logic [1:0] ERR_RESP = RESP_DECERR
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_REGS-1:0]    sel_i,
  input  logic                 arvalid_i,
  output logic                 arready_o,
  output logic [DW-1:0]        rdata_o,
  output logic [1:0]           rresp_o,
  output logic                 rvalid_o,
  input  logic                 rready_i,
  input  logic [N_REGS*DW-1:0] regs_i,
  output logic                 fire_o,
  output logic [N_REGS-1:0]    hit_o
);
  logic [DW-1:0] mux;

  assign arready_o = !rvalid_o;
  assign fire_o    = arvalid_i && arready_o;

  always_comb begin
    mux = '0;
    for (int i = 0; i < N_REGS; i++)
      if (sel_i[i]) mux |= regs_i[i*DW +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      rresp_o  <= RESP_OKAY;
      hit_o    <= '0;
    end else begin
      hit_o <= fire_o ? sel_i : '0;
      if (fire_o) begin
        rvalid_o <= 1'b1;
        rdata_o  <= mux;
        rresp_o  <= (|sel_i) ? RESP_OKAY : ERR_RESP;
      end else if (rvalid_o && rready_i) begin
        rvalid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/axil_regfile.sv
module axil_regfile import axil_regfile_pkg::*; #(
  parameter int                    N_REGS      = 8,
  parameter int                    AW          = 32,
  parameter logic [N_REGS*AW-1:0]  REG_ADDR    = {32'h24, 32'h18, 32'h14, 32'h10,
                                                  32'h0C, 32'h08, 32'h04, 32'h00},
  parameter logic [N_REGS*4-1:0]   REG_MODE    = {M_STICKY_LO, M_STICKY_HI, M_LATCH_WR, M_LATCH_RD,
                                                  M_CTRL, M_PASS, M_STAT, M_CONST},
  parameter logic [N_REGS*DW-1:0]  REG_INIT    = {32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0,
                                                  32'h0000_1200, 32'h0, 32'h0, 32'h0000_0003},
  parameter logic [N_REGS*DW-1:0]  REG_CLR     = {32'h0, 32'h0, 32'h0, 32'h0,
                                                  32'h0000_0001, 32'h0, 32'h0, 32'h0},
  parameter logic [1:0]            ERR_RESP    = RESP_DECERR,
  parameter bit                    IGNORE_HIGH = 1'b1,
  parameter bit                    RST_INIT    = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AW-1:0]        s_awaddr_i,
  input  logic                 s_awvalid_i,
  output logic                 s_awready_o,
  input  logic [DW-1:0]        s_wdata_i,
  input  logic [3:0]           s_wstrb_i,
  input  logic                 s_wvalid_i,
  output logic                 s_wready_o,
  output logic [1:0]           s_bresp_o,
  output logic                 s_bvalid_o,
  input  logic                 s_bready_i,
  input  logic [AW-1:0]        s_araddr_i,
  input  logic                 s_arvalid_i,
  output logic                 s_arready_o,
  output logic [DW-1:0]        s_rdata_o,
  output logic [1:0]           s_rresp_o,
  output logic                 s_rvalid_o,
  input  logic                 s_rready_i,
  output logic [N_REGS*DW-1:0] reg_q_o,
  input  logic [N_REGS*DW-1:0] fab_d_i,
  input  logic [N_REGS-1:0]    fab_stb_i,
  output logic [N_REGS-1:0]    wr_hit_o,
  output logic [N_REGS-1:0]    rd_hit_o
);
  // Address bits needed to reach the end of the highest register
  function automatic int dec_bits();
    logic [AW:0] top_end;
    logic [AW:0] e;
    top_end = '0;
    for (int i = 0; i < N_REGS; i++) begin
      e = {1'b0, REG_ADDR[i*AW +: AW]} + (AW+1)'(4);
      if (e > top_end) top_end = e;
    end
    return $clog2(top_end);
  endfunction

  localparam int          DEC_W    = dec_bits();
  localparam logic [AW-1:0] WORD_M = ~AW'(3);
  localparam logic [AW-1:0] DEC_MASK = IGNORE_HIGH ? (AW'((64'd1 << DEC_W) - 64'd1) & WORD_M) : WORD_M;

  function automatic logic [N_REGS-1:0] decode(input logic [AW-1:0] a);
    logic [N_REGS-1:0] s;
    for (int i = 0; i < N_REGS; i++)
      s[i] = ((a ^ REG_ADDR[i*AW +: AW]) & DEC_MASK) == '0;
    return s;
  endfunction

  logic              wr_fire, rd_fire;
  logic [AW-1:0]     wr_addr;
  logic [DW-1:0]     wr_data;
  logic [3:0]        wr_strb;
  logic [N_REGS-1:0] wsel, rsel;

  assign wsel = decode(wr_addr);
  assign rsel = decode(s_araddr_i);

  axil_regfile_wr #(.AW(AW), .ERR_RESP(ERR_RESP)) i_wr (
    .clk_i, .rst_ni,
    .awaddr_i (s_awaddr_i), .awvalid_i(s_awvalid_i), .awready_o(s_awready_o),
    .wdata_i  (s_wdata_i),  .wstrb_i  (s_wstrb_i),   .wvalid_i (s_wvalid_i),
    .wready_o (s_wready_o), .bresp_o  (s_bresp_o),   .bvalid_o (s_bvalid_o),
    .bready_i (s_bready_i), .miss_i   (~|wsel),      .fire_o   (wr_fire),
    .addr_o   (wr_addr),    .data_o   (wr_data),     .strb_o   (wr_strb)
  );

  axil_regfile_rd #(.N_REGS(N_REGS), .ERR_RESP(ERR_RESP)) i_rd (
    .clk_i, .rst_ni,
    .sel_i    (rsel),       .arvalid_i(s_arvalid_i), .arready_o(s_arready_o),
    .rdata_o  (s_rdata_o),  .rresp_o  (s_rresp_o),   .rvalid_o (s_rvalid_o),
    .rready_i (s_rready_i), .regs_i   (reg_q_o),     .fire_o   (rd_fire),
    .hit_o    (rd_hit_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_hit_o <= '0;
    else         wr_hit_o <= wr_fire ? wsel : '0;
  end

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    axil_regfile_cell #(
      .MODE    (REG_MODE[i*4 +: 4]),
      .INIT    (REG_INIT[i*DW +: DW]),
      .CLR     (REG_CLR[i*DW +: DW]),
      .RST_INIT(RST_INIT)
    ) i_cell (
      .clk_i, .rst_ni,
      .bus_wr_i(wr_fire && wsel[i]),
      .bus_rd_i(rd_fire && rsel[i]),
      .wdata_i (wr_data),
      .wstrb_i (wr_strb),
      .stb_i   (fab_stb_i[i]),
      .d_i     (fab_d_i[i*DW +: DW]),
      .q_o     (reg_q_o[i*DW +: DW])
    );
  end
endmodule

// File: rtl/axil_regfile_chk.sv
module axil_regfile_chk import axil_regfile_pkg::*; #(
  parameter int                   N_REGS   = 8,
  parameter logic [N_REGS*4-1:0]  REG_MODE = '0,
  parameter logic [N_REGS*DW-1:0] REG_INIT = '0,
  parameter logic [N_REGS*DW-1:0] REG_CLR  = '0
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 s_bvalid_o,
  input logic                 s_bready_i,
  input logic [1:0]           s_bresp_o,
  input logic                 s_rvalid_o,
  input logic                 s_rready_i,
  input logic [DW-1:0]        s_rdata_o,
  input logic [1:0]           s_rresp_o,
  input logic [N_REGS-1:0]    wr_hit_o,
  input logic [N_REGS-1:0]    rd_hit_o,
  input logic [N_REGS-1:0]    fab_stb_i,
  input logic [N_REGS*DW-1:0] reg_q_o
);
  AST_WR_HIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_hit_o)); // R2
  AST_WR_HIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_hit_o) |=> (~|wr_hit_o)); // R2
  AST_RD_HIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rd_hit_o) |=> (~|rd_hit_o)); // R2
  AST_B_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_bvalid_o && !s_bready_i) |=> (s_bvalid_o && $stable(s_bresp_o))); // R10
  AST_R_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_rvalid_o && !s_rready_i) |=> (s_rvalid_o && $stable(s_rdata_o) && $stable(s_rresp_o))); // R10

  for (genvar i = 0; i < N_REGS; i++) begin : g_chk
    localparam mode_t         MD = REG_MODE[i*4 +: 4];
    localparam logic [DW-1:0] IV = REG_INIT[i*DW +: DW];
    localparam logic [DW-1:0] CM = REG_CLR[i*DW +: DW];
    if (MD == M_CTRL && CM != '0) begin : g_ctrl
      AST_AUTOCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(reg_q_o[i*DW +: DW] & CM)) |=>
        ((~|(reg_q_o[i*DW +: DW] & CM)) || wr_hit_o[i] || $past(fab_stb_i[i]))); // R5
    end
    if (MD == M_LATCH_RD) begin : g_lrd
      AST_LATCH_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_q_o[i*DW +: DW] != IV) |=>
        ((reg_q_o[i*DW +: DW] == $past(reg_q_o[i*DW +: DW])) || rd_hit_o[i])); // R7
    end
    if (MD == M_LATCH_WR) begin : g_lwr
      AST_LATCH_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_q_o[i*DW +: DW] != IV) |=>
        ((reg_q_o[i*DW +: DW] == $past(reg_q_o[i*DW +: DW])) || wr_hit_o[i])); // R7
    end
  end
endmodule

bind axil_regfile axil_regfile_chk #(
  .N_REGS(N_REGS), .REG_MODE(REG_MODE), .REG_INIT(REG_INIT), .REG_CLR(REG_CLR)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .s_bvalid_o(s_bvalid_o), .s_bready_i(s_bready_i), .s_bresp_o(s_bresp_o),
  .s_rvalid_o(s_rvalid_o), .s_rready_i(s_rready_i), .s_rdata_o(s_rdata_o),
  .s_rresp_o(s_rresp_o), .wr_hit_o(wr_hit_o), .rd_hit_o(rd_hit_o),
  .fab_stb_i(fab_stb_i), .reg_q_o(reg_q_o)
);

// File: tb/test_axil_regfile.sv
`timescale 1ns/1ps
module test_axil_regfile;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [31:0]   awaddr = '0, wdata = '0, araddr = '0;
  logic [3:0]    wstrb = '0;
  logic          awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
  logic          awready, wready, bvalid, arready, rvalid;
  logic [1:0]    bresp, rresp;
  logic [31:0]   rdata;
  logic [N*32-1:0] reg_q, fab_d = '0;
  logic [N-1:0]  fab_stb = '0, wr_hit, rd_hit;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  axil_regfile i_axil_regfile (
    .clk_i(clk), .rst_ni(rst_ni),
    .s_awaddr_i(awaddr), .s_awvalid_i(awvalid), .s_awready_o(awready),
    .s_wdata_i(wdata), .s_wstrb_i(wstrb), .s_wvalid_i(wvalid), .s_wready_o(wready),
    .s_bresp_o(bresp), .s_bvalid_o(bvalid), .s_bready_i(bready),
    .s_araddr_i(araddr), .s_arvalid_i(arvalid), .s_arready_o(arready),
    .s_rdata_o(rdata), .s_rresp_o(rresp), .s_rvalid_o(rvalid), .s_rready_i(rready),
    .reg_q_o(reg_q), .fab_d_i(fab_d), .fab_stb_i(fab_stb),
    .wr_hit_o(wr_hit), .rd_hit_o(rd_hit)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [1:0]  resp;
    logic [31:0] rdata;
    logic [7:0]  hit;
  } vec_t;

  localparam int N_VEC = 12;
  localparam vec_t VEC [N_VEC] = '{
    '{1'b0, 32'h0000_0000, 32'h0,         4'h0,   2'b00, 32'h0000_0003, 8'h01}, // R6 constant read
    '{1'b0, 32'h0000_000C, 32'h0,         4'h0,   2'b00, 32'h0000_1200, 8'h08}, // R1 init value
    '{1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 4'hF,   2'b00, 32'h0,         8'h01}, // R6 write to constant
    '{1'b0, 32'h0000_0000, 32'h0,         4'h0,   2'b00, 32'h0000_0003, 8'h01}, // R6 still constant
    '{1'b1, 32'h0000_000C, 32'hAABB_CCDD, 4'b0100, 2'b00, 32'h0,        8'h08}, // R5 byte enable
    '{1'b0, 32'h0000_000C, 32'h0,         4'h0,   2'b00, 32'h00BB_1200, 8'h08}, // R5 partial result
    '{1'b0, 32'h0000_0020, 32'h0,         4'h0,   2'b11, 32'h0,         8'h00}, // R3 hole read
    '{1'b1, 32'h0000_0030, 32'h1234_5678, 4'hF,   2'b11, 32'h0,         8'h00}, // R3 hole write
    '{1'b0, 32'h8000_000C, 32'h0,         4'h0,   2'b00, 32'h00BB_1200, 8'h08}, // R4 high bits dropped
    '{1'b0, 32'h0000_0024, 32'h0,         4'h0,   2'b00, 32'hFFFF_FFFF, 8'h80}, // R8 sticky-low init
    '{1'b0, 32'h0000_001C, 32'h0,         4'h0,   2'b11, 32'h0,         8'h00}, // R3 hole below top
    '{1'b0, 32'h0000_0008, 32'h0,         4'h0,   2'b00, 32'h0,         8'h04}  // R6 pass-through
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] q(input int i);
    return reg_q[i*32 +: 32];
  endfunction

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                        output logic [1:0] r, output logic [7:0] h, output logic [N*32-1:0] qs);
    @(negedge clk);
    awaddr = a; awvalid = 1'b1; wdata = d; wstrb = s; wvalid = 1'b1;
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    while (!bvalid) @(negedge clk);
    r = bresp; h = wr_hit; qs = reg_q;
    @(negedge clk);
    chk("R10 bvalid held", {31'b0, bvalid}, 32'd1);
    chk("R10 bresp stable", {30'b0, bresp}, {30'b0, r});
    bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;
  endtask

  task automatic rd_finish(input logic [31:0] d);
    @(negedge clk);
    chk("R10 rvalid held", {31'b0, rvalid}, 32'd1);
    chk("R10 rdata stable", rdata, d);
    rready = 1'b1;
    @(negedge clk);
    rready = 1'b0;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] d,
                        output logic [1:0] r, output logic [7:0] h);
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    @(negedge clk);
    arvalid = 1'b0;
    d = rdata; r = rresp; h = rd_hit;
    rd_finish(d);
  endtask

  // read accepted on the same edge that samples a fabric strobe
  task automatic rd_with_stb(input logic [31:0] a, input int idx, input logic [31:0] v,
                             output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    fab_d[idx*32 +: 32] = v; fab_stb[idx] = 1'b1;
    @(negedge clk);
    arvalid = 1'b0; fab_stb[idx] = 1'b0;
    d = rdata;
    rd_finish(d);
  endtask

  task automatic strobe(input int idx, input logic [31:0] v);
    @(negedge clk);
    fab_d[idx*32 +: 32] = v; fab_stb[idx] = 1'b1;
    @(negedge clk);
    fab_stb[idx] = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL R10 watchdog act=hung exp=complete");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [1:0]  r;
    logic [7:0]  h;
    logic [N*32-1:0] qs;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 const init", q(0), 32'h3);
    chk("R1 ctrl init", q(3), 32'h1200);
    chk("R1 latch init", q(4), 32'h0);
    chk("R1 sticky-low init", q(7), 32'hFFFF_FFFF);
    chk("R1 no responses", {30'b0, bvalid, rvalid}, 32'h0);
    chk("R1 hits low", {16'b0, wr_hit, rd_hit}, 32'h0);
    rst_ni = 1'b1;

    for (int k = 0; k < N_VEC; k++) begin
      if (VEC[k].wr) begin
        bus_wr(VEC[k].addr, VEC[k].data, VEC[k].strb, r, h, qs);
        chk($sformatf("vec %0d R2 write hit", k), {24'b0, h}, {24'b0, VEC[k].hit});
        chk($sformatf("vec %0d R3 write resp", k), {30'b0, r}, {30'b0, VEC[k].resp});
      end else begin
        bus_rd(VEC[k].addr, d, r, h);
        chk($sformatf("vec %0d R2 read hit", k), {24'b0, h}, {24'b0, VEC[k].hit});
        chk($sformatf("vec %0d R3 read resp", k), {30'b0, r}, {30'b0, VEC[k].resp});
        chk($sformatf("vec %0d R4 R5 R6 rdata", k), d, VEC[k].rdata);
      end
    end

    // R5 auto-clear after bus write and after fabric strobe
    bus_wr(32'h0C, 32'h0000_1201, 4'hF, r, h, qs);
    chk("R5 autoclr bit set on write", qs[3*32 +: 32], 32'h0000_1201);
    chk("R5 autoclr bit dropped", q(3), 32'h0000_1200);
    strobe(3, 32'h0000_5501);
    chk("R5 strobe loads word", q(3), 32'h0000_5501);
    @(negedge clk);
    chk("R5 strobe bit dropped", q(3), 32'h0000_5500);

    // R11 registered status
    strobe(1, 32'h0000_ABCD);
    chk("R11 status capture", q(1), 32'h0000_ABCD);
    bus_wr(32'h04, 32'h1111_1111, 4'hF, r, h, qs);
    chk("R11 write ignored", q(1), 32'h0000_ABCD);
    chk("R2 status write hit", {24'b0, h}, 32'h02);
    bus_rd(32'h04, d, r, h);
    chk("R11 status read", d, 32'h0000_ABCD);

    // R6 pass-through
    fab_d[2*32 +: 32] = 32'h1234_5678;
    #0.1;
    chk("R6 pass-through out", q(2), 32'h1234_5678);
    bus_rd(32'h08, d, r, h);
    chk("R6 pass-through read", d, 32'h1234_5678);

    // R7 latch, read-clear
    strobe(4, 32'h11);
    strobe(4, 32'h22);
    chk("R7 latch frozen", q(4), 32'h11);
    bus_rd(32'h10, d, r, h);
    chk("R7 latch read value", d, 32'h11);
    chk("R7 latch cleared", q(4), 32'h0);
    strobe(4, 32'h22);
    chk("R7 latch recaptures", q(4), 32'h22);

    // R9 read clear vs strobe on latch
    rd_with_stb(32'h10, 4, 32'h33, d);
    chk("R9 latch read prior", d, 32'h22);
    chk("R9 latch strobe dropped", q(4), 32'h0);
    strobe(4, 32'h44);
    chk("R9 latch next strobe", q(4), 32'h44);

    // R7 latch, write-clear
    strobe(5, 32'h77);
    strobe(5, 32'h88);
    chk("R7 wlatch frozen", q(5), 32'h77);
    bus_wr(32'h14, 32'hDEAD, 4'hF, r, h, qs);
    chk("R7 wlatch cleared, data discarded", q(5), 32'h0);
    strobe(5, 32'h88);
    chk("R7 wlatch recaptures", q(5), 32'h88);

    // R8 sticky-high
    strobe(6, 32'h05);
    strobe(6, 32'h30);
    chk("R8 sticky-high or", q(6), 32'h35);
    bus_rd(32'h18, d, r, h);
    chk("R8 sticky-high read", d, 32'h35);
    chk("R8 sticky-high cleared", q(6), 32'h0);

    // R9 read clear vs strobe on sticky-high
    strobe(6, 32'h05);
    rd_with_stb(32'h18, 6, 32'h30, d);
    chk("R9 sticky read prior", d, 32'h05);
    chk("R9 sticky strobe dropped", q(6), 32'h0);

    // R8 sticky-low
    strobe(7, 32'hFFFF_FF0F);
    strobe(7, 32'hFFFF_F0FF);
    chk("R8 sticky-low and", q(7), 32'hFFFF_F00F);
    bus_rd(32'h24, d, r, h);
    chk("R8 sticky-low read", d, 32'hFFFF_F00F);
    chk("R8 sticky-low set", q(7), 32'hFFFF_FFFF);

    summary();
  end
endmodule